// File: doc/BRIEF.md
# Energy-Threshold Backup and Restore Manager

This block sits beside the controller of an energy-harvesting node and watches a digital measure of the charge held in the storage capacitor. Each cycle it sorts that value into one of four supply zones (off, backup, safe, active) and turns zone changes into the three actions that protect the node's registers: a one-cycle request to copy the essential registers into non-volatile memory, a shutdown indication when the charge is too low to keep volatile state alive, and a restore request when the node comes back after its volatile state was really lost.

The safe zone is a fixed margin above the backup level. Charge that dips into that band but stays at or above the backup level never causes a non-volatile write. After a backup, a new backup is allowed only once the charge has climbed back to the safe level or higher, so a value that wobbles around the backup level does not cause a string of writes. If charging recovers after a backup but before the off level is reached, the volatile registers are still good and no restore is asked for. A restore is requested only after a real shutdown, once the charge reaches the active level. It stays raised until the memory side acknowledges it, and only then does the state-valid flag rise.

The three thresholds are run-time inputs. Wrong ordering among them is reported on a registered status output.

Top module: `nv_guard`

## Requirements
- R1: `zone` reports the zone of the `energy` sample taken one cycle earlier, encoded 0 = off (energy < off level), 1 = backup (off level <= energy < backup level), 2 = safe (backup level <= energy < backup level + SAFE_MARGIN), 3 = active (energy >= backup level + SAFE_MARGIN).
- R2: Energy in the safe zone never raises `backup_req`.
- R3: When energy is sampled in the off or backup zone while a backup is armed, `backup_req` is high for exactly one cycle, two cycles after the sample. Further samples below the backup level, such as slow leakage while asleep, raise no more requests.
- R4: A backup is armed only after energy is sampled in the active zone while volatile state is not lost. Returning only to the safe zone does not re-arm it.
- R5: Two cycles after energy is sampled in the off zone, `shutdown` is 1 and `state_valid` is 0, and volatile state counts as lost.
- R6: While volatile state is lost, `restore_req` rises and `shutdown` falls two cycles after energy is sampled at or above the active level. `restore_req` then stays high until `restore_ack` is sampled high, unless energy returns to the off zone first.
- R7: `state_valid` rises, and `restore_req` falls, one cycle after `restore_ack` is sampled high while `restore_req` is high.
- R8: After a backup, if energy recovers without entering the off zone, `restore_req` stays 0 and `state_valid` stays 1.
- R9: When energy falls from the active zone straight into the off zone, `backup_req` and `shutdown` rise in the same cycle. A `restore_ack` sampled in the same cycle as an off-zone zone value is ignored, and `state_valid` stays 0.
- R10: `cfg_err` is 1, one cycle after the thresholds are sampled, exactly when the ordering off level < backup level < backup level + SAFE_MARGIN < active level fails. The sum is taken without wrap-around.
- R11: While and right after reset, `shutdown` is 1, `zone` is 0, and `backup_req`, `restore_req` and `state_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| energy | input | EW | Stored-energy sample |
| th_off | input | EW | Level below which volatile state is lost |
| th_bkp | input | EW | Level below which a backup is taken |
| th_active | input | EW | Level needed to restore after shutdown |
| restore_ack | input | 1 | Memory side has finished the restore |
| zone | output | 2 | Current supply zone (encoding in R1) |
| backup_req | output | 1 | One-cycle request to save registers |
| shutdown | output | 1 | Volatile state is lost or not yet restored |
| restore_req | output | 1 | Request to reload registers, held until acknowledged |
| state_valid | output | 1 | Register contents are usable |
| cfg_err | output | 1 | Threshold ordering violated |

## Verification
Two functions can fall in the same cycle. The first case is a backup and a shutdown: the bench arms a backup, then moves energy in one step from the active zone to the off zone, and expects `backup_req` and `shutdown` high together two cycles later. The second case is a restore acknowledge arriving in the same cycle that the off zone takes effect. The bench holds `restore_req` pending, drives energy to zero, and raises `restore_ack` just after the off zone has been registered. Shutdown must win: `state_valid` stays 0 and `restore_req` drops.

// File: rtl/nv_guard_pkg.sv
package nv_guard_pkg;
  typedef enum logic [1:0] {
    ZN_OFF  = 2'd0,
    ZN_BKUP = 2'd1,
    ZN_SAFE = 2'd2,
    ZN_ACT  = 2'd3
  } zone_e;
endpackage

// File: rtl/nv_guard_zone.sv
module nv_guard_zone
  import nv_guard_pkg::*;
#(
  parameter int EW          = 8,
  parameter int SAFE_MARGIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] energy,
  input  logic [EW-1:0] th_off,
  input  logic [EW-1:0] th_bkp,
  input  logic [EW-1:0] th_active,
  output zone_e         zone_q,
  output logic          ge_active_q,
  output logic          cfg_err_q
);
  localparam int XW = EW + 1;
  localparam logic [XW-1:0] MARGIN_X = XW'(SAFE_MARGIN);

  logic [XW-1:0] safe_lvl;
  logic [XW-1:0] e_x;
  zone_e         zone_d;
  logic          order_ok;

  assign safe_lvl = {1'b0, th_bkp} + MARGIN_X;
  assign e_x      = {1'b0, energy};

  always_comb begin
    if (energy < th_off)       zone_d = ZN_OFF;
    else if (energy < th_bkp)  zone_d = ZN_BKUP;
    else if (e_x < safe_lvl)   zone_d = ZN_SAFE;
    else                       zone_d = ZN_ACT;
  end

  assign order_ok = (th_off < th_bkp) && ({1'b0, th_bkp} < safe_lvl) &&
                    (safe_lvl < {1'b0, th_active});

  always_ff @(posedge clk) begin
    if (rst) begin
      zone_q      <= ZN_OFF;
      ge_active_q <= 1'b0;
      cfg_err_q   <= 1'b0;
    end else begin
      zone_q      <= zone_d;
      ge_active_q <= (energy >= th_active);
      cfg_err_q   <= !order_ok;
    end
  end

  // R1: a sample below the off level yields the off zone next cycle
  p_off_zone_r1: assert property (@(posedge clk) disable iff (rst)
    (energy < th_off) |=> (zone_q == ZN_OFF));
endmodule

// File: rtl/nv_guard_bkp.sv
module nv_guard_bkp
  import nv_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  zone_e zone_q,
  input  logic  lost_q,
  output logic  backup_req
);
  logic armed_q;
  logic low;

  assign low = (zone_q == ZN_OFF) || (zone_q == ZN_BKUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      backup_req <= 1'b0;
    end else begin
      backup_req <= 1'b0;
      if (armed_q && low) begin
        backup_req <= 1'b1;
        armed_q    <= 1'b0;
      end else if (lost_q) begin
        armed_q <= 1'b0;
      end else if (zone_q == ZN_ACT) begin
        armed_q <= 1'b1;
      end
    end
  end

  // R2: safe zone never leads to a request
  p_no_bkp_safe_r2: assert property (@(posedge clk) disable iff (rst)
    (zone_q == ZN_SAFE) |=> !backup_req);
  // R3: a request lasts a single cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    backup_req |=> !backup_req);
endmodule

// File: rtl/nv_guard_rst.sv
module nv_guard_rst
  import nv_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  zone_e zone_q,
  input  logic  ge_active_q,
  input  logic  restore_ack,
  output logic  lost_q,
  output logic  shutdown,
  output logic  restore_req,
  output logic  state_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lost_q      <= 1'b1;
      shutdown    <= 1'b1;
      restore_req <= 1'b0;
      state_valid <= 1'b0;
    end else if (zone_q == ZN_OFF) begin
      lost_q      <= 1'b1;
      shutdown    <= 1'b1;
      restore_req <= 1'b0;
      state_valid <= 1'b0;
    end else if (lost_q && !restore_req && ge_active_q) begin
      restore_req <= 1'b1;
      shutdown    <= 1'b0;
    end else if (restore_req && restore_ack) begin
      restore_req <= 1'b0;
      lost_q      <= 1'b0;
      state_valid <= 1'b1;
    end
  end

  // R5: off zone forces shutdown and invalid state
  p_off_shut_r5: assert property (@(posedge clk) disable iff (rst)
    (zone_q == ZN_OFF) |=> (shutdown && !state_valid));
  // R6: restore request held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !restore_ack && zone_q != ZN_OFF) |=> restore_req);
  // R7: validity only follows an accepted acknowledge
  p_valid_ack_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(state_valid) |-> $past(restore_req && restore_ack));
endmodule

// File: rtl/nv_guard.sv
module nv_guard
  import nv_guard_pkg::*;
#(
  parameter int EW          = 8,
  parameter int SAFE_MARGIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] energy,
  input  logic [EW-1:0] th_off,
  input  logic [EW-1:0] th_bkp,
  input  logic [EW-1:0] th_active,
  input  logic          restore_ack,
  output logic [1:0]    zone,
  output logic          backup_req,
  output logic          shutdown,
  output logic          restore_req,
  output logic          state_valid,
  output logic          cfg_err
);
  zone_e zone_q;
  logic  ge_active_q;
  logic  lost_q;

  nv_guard_zone #(.EW(EW), .SAFE_MARGIN(SAFE_MARGIN)) u_zone (
    .clk(clk), .rst(rst), .energy(energy), .th_off(th_off),
    .th_bkp(th_bkp), .th_active(th_active), .zone_q(zone_q),
    .ge_active_q(ge_active_q), .cfg_err_q(cfg_err)
  );

  nv_guard_bkp u_bkp (
    .clk(clk), .rst(rst), .zone_q(zone_q), .lost_q(lost_q),
    .backup_req(backup_req)
  );

  nv_guard_rst u_rst (
    .clk(clk), .rst(rst), .zone_q(zone_q), .ge_active_q(ge_active_q),
    .restore_ack(restore_ack), .lost_q(lost_q), .shutdown(shutdown),
    .restore_req(restore_req), .state_valid(state_valid)
  );

  assign zone = zone_q;
endmodule

// File: tb/nv_guard_bench.sv
module nv_guard_bench;
  localparam int EW = 5;
  localparam int MG = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [EW-1:0] energy = '0;
  logic [EW-1:0] th_off = 5'd4;
  logic [EW-1:0] th_bkp = 5'd8;
  logic [EW-1:0] th_active = 5'd14;
  logic          restore_ack = 1'b0;
  logic [1:0]    zone;
  logic          backup_req, shutdown, restore_req, state_valid, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  int bk_cnt  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  nv_guard #(.EW(EW), .SAFE_MARGIN(MG)) u_nv_guard (
    .clk(clk), .rst(rst), .energy(energy), .th_off(th_off),
    .th_bkp(th_bkp), .th_active(th_active), .restore_ack(restore_ack),
    .zone(zone), .backup_req(backup_req), .shutdown(shutdown),
    .restore_req(restore_req), .state_valid(state_valid), .cfg_err(cfg_err)
  );

  always @(posedge clk) if (!rst && backup_req) bk_cnt++;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_ack();
    restore_ack = 1'b1;
    step(1);
    restore_ack = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R11 shutdown", shutdown, 1);
    chk("R11 zone", zone, 0);
    chk("R11 backup_req", backup_req, 0);
    chk("R11 restore_req", restore_req, 0);
    chk("R11 state_valid", state_valid, 0);
    rst = 1'b0;
    step(2);
    chk("R11 shutdown after release", shutdown, 1);
    chk("R10 good order", cfg_err, 0);

    // R6 and R7: power-up restore
    energy = 5'd20; step(2);
    chk("R6 restore_req", restore_req, 1);
    chk("R6 shutdown cleared", shutdown, 0);
    step(5);
    chk("R6 restore_req held", restore_req, 1);
    do_ack();
    chk("R7 state_valid", state_valid, 1);
    chk("R7 restore_req dropped", restore_req, 0);
    step(2);

    // R2: safe zone
    energy = 5'd9; step(4);
    chk("R2 no backup at 9", bk_cnt, 0);
    energy = 5'd8; step(3);
    chk("R2 no backup at 8", bk_cnt, 0);

    // R3: leakage drift below the backup level
    energy = 5'd7; step(3);
    chk("R3 one backup", bk_cnt, 1);
    energy = 5'd6; step(3);
    energy = 5'd5; step(3);
    chk("R3 still one backup", bk_cnt, 1);
    chk("R8 no shutdown", shutdown, 0);

    // R4: re-arm only via active zone
    energy = 5'd9; step(3);
    energy = 5'd7; step(3);
    chk("R4 safe does not rearm", bk_cnt, 1);
    energy = 5'd12; step(3);
    chk("R8 no restore", restore_req, 0);
    chk("R8 state_valid kept", state_valid, 1);
    energy = 5'd7; step(3);
    chk("R4 rearmed backup", bk_cnt, 2);

    // R5: off zone
    energy = 5'd3; step(2);
    chk("R5 shutdown", shutdown, 1);
    chk("R5 state_valid", state_valid, 0);
    chk("R5 no extra backup", bk_cnt, 2);

    // R6: needs active level
    energy = 5'd12; step(3);
    chk("R6 no restore below active", restore_req, 0);
    chk("R6 still shut", shutdown, 1);
    energy = 5'd15; step(2);
    chk("R6 restore at active", restore_req, 1);
    do_ack();
    chk("R7 valid again", state_valid, 1);
    step(2);

    // R9: backup and shutdown in one cycle
    energy = 5'd1; step(2);
    chk("R9 backup_req", backup_req, 1);
    chk("R9 shutdown", shutdown, 1);
    step(2);
    chk("R9 one backup", bk_cnt, 3);

    // R9: acknowledge coinciding with off zone
    energy = 5'd20; step(2);
    chk("R9 pending restore", restore_req, 1);
    energy = 5'd0; step(1);
    restore_ack = 1'b1; step(1);
    restore_ack = 1'b0;
    chk("R9 ack ignored valid", state_valid, 0);
    chk("R9 restore dropped", restore_req, 0);
    step(2);
    chk("R9 valid stays 0", state_valid, 0);

    // R10: threshold ordering sweep
    for (int o = 0; o < 32; o += 3)
      for (int b = 0; b < 32; b += 3)
        for (int a = 0; a < 32; a += 3) begin
          th_off = EW'(o); th_bkp = EW'(b); th_active = EW'(a);
          step(1);
          chk("R10 cfg_err", cfg_err, ((o < b) && (b + MG < a)) ? 0 : 1);
        end
    th_off = 5'd10; th_bkp = 5'd31; th_active = 5'd31;
    step(1);
    chk("R10 no wrap", cfg_err, 1);
    th_off = 5'd4; th_bkp = 5'd8; th_active = 5'd14;

    // R1: zone sweep
    for (int e = 0; e < 32; e++) begin
      int ez;
      energy = EW'(e);
      step(1);
      ez = (e < 4) ? 0 : (e < 8) ? 1 : (e < 8 + MG) ? 2 : 3;
      chk("R1 zone", zone, ez);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule